// File: doc/BRIEF.md
# DDR3 Write Burst Timing Sequencer

This block sits on the controller side of a DDR3 interface. It handles one write burst at a time. It accepts a write request that carries a bank, a column, the address bit that requests burst chop, eight beats of data and eight beats of mask. It places the WRITE command on a small encoded command bus. After the write latency it produces the strobe preamble, the data beats and the strobe postamble. It then blocks a PRECHARGE to the bank just written until write recovery has run out. A PRECHARGE to a different bank may go out at any time.

Strobe, data and mask are given per clock as a rising-phase value and a falling-phase value. The whole block therefore runs on one clock, and a physical layer downstream serialises the two phases. The mode-register burst-length field picks between a fixed 8-beat burst, a fixed 4-beat chop, and an on-the-fly choice taken from address bit 12 of each request. Write latency and write recovery are parameters counted in clocks.

Top module: `wrburst_seq`

## Requirements
- R1: During reset and straight after it, `cmd_o` is NOP (2'd0), `dqs_oe`, `dq_oe`, `pre_ack` are low and `req_ready` is high.
- R2: A request taken at a clock edge (`req_valid` and `req_ready` both high) gives `cmd_o` = WRITE (2'd1) in the next cycle, called cycle 0. In cycle 0 `cmd_bank`, `cmd_col` and `cmd_a12` carry the request's values. `req_ready` stays low from cycle 0 through the last cycle of write recovery.
- R3: Burst length comes from `mode_bl`. With 2'b01 (on-the-fly), `req_a12` = 0 gives 4 beats and 1 gives 8 beats. 2'b00 and 2'b11 give 8 beats and 2'b10 gives 4 beats, whatever `req_a12` is.
- R4: Data beats occupy the clock cycles WL through WL+B/2-1, where B is the beat count. In cycle WL+j, beat 2j is on `dq_rise` and beat 2j+1 is on `dq_fall`. Beat i is `req_data[i*DW +: DW]`. `dq_oe` is high only in those cycles, and the data outputs are zero elsewhere.
- R5: In cycle WL-1 (preamble), `dqs_oe` = 1, `dqs_rise` = 1 and `dqs_fall` = 0. The strobe is high for the first half clock and low for the half clock before data.
- R6: In every data cycle the strobe is 1 on the rising phase and 0 on the falling phase. In cycle WL+B/2 (postamble), `dqs_oe` = 1 with both phases 0. From the next cycle `dqs_oe` is 0.
- R7: Mask beats follow the data alignment: beat i is `req_mask[i*MW +: MW]`, beat 2j is on `dm_rise` and beat 2j+1 is on `dm_fall` in cycle WL+j.
- R8: A PRECHARGE (2'd2) to the bank just written appears on `cmd_o` no earlier than cycle WL+B/2+TWR. When `pre_req` is held from cycle 0, it appears exactly in that cycle.
- R9: A PRECHARGE request to a different bank is taken at once during a burst. `pre_ack` is high in the cycle it is taken, and `cmd_o` shows PRECHARGE with `cmd_bank` = `pre_bank` one cycle later.
- R10: A pending `pre_req` has priority over a write. `req_ready` is low while `pre_req` is high, and no WRITE is issued at that edge.
- R11: Every cycle that carries neither a WRITE nor a PRECHARGE shows NOP on `cmd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_bl | input | 2 | Mode-register burst-length field |
| req_valid | input | 1 | Write request present |
| req_bank | input | BW | Bank of the write |
| req_col | input | CLW | Start column of the write |
| req_a12 | input | 1 | Address bit 12, selects the on-the-fly burst length |
| req_data | input | 8*DW | Eight data beats, beat 0 in the low bits |
| req_mask | input | 8*MW | Eight mask beats, beat 0 in the low bits |
| req_ready | output | 1 | Sequencer can take a write this cycle |
| pre_req | input | 1 | Precharge request |
| pre_bank | input | BW | Bank to precharge |
| pre_ack | output | 1 | Precharge request taken at this edge |
| cmd_o | output | 2 | Command: 0 NOP, 1 WRITE, 2 PRECHARGE |
| cmd_bank | output | BW | Bank of the command |
| cmd_col | output | CLW | Column of the WRITE |
| cmd_a12 | output | 1 | Address bit 12 of the WRITE |
| dqs_oe | output | 1 | Strobe drive enable |
| dqs_rise | output | 1 | Strobe level in the rising half clock |
| dqs_fall | output | 1 | Strobe level in the falling half clock |
| dq_oe | output | 1 | Data drive enable |
| dq_rise | output | DW | Data beat in the rising half clock |
| dq_fall | output | DW | Data beat in the falling half clock |
| dm_rise | output | MW | Mask beat in the rising half clock |
| dm_fall | output | MW | Mask beat in the falling half clock |

## Verification
The assertions check four things on every cycle:
- every WRITE follows an accepted request, and the block is busy right after it;
- data is driven only inside the strobe window;
- each burst opens with a preamble cycle that is high then low, and closes with a low postamble;
- a same-bank PRECHARGE never comes earlier than write latency plus burst length plus recovery, as counted by the checker.

The bench scenarios cover what needs exact expected values:
- the burst-length choice for each mode-field setting with both values of bit 12;
- the cycle-by-cycle beat order of data and mask;
- the exact earliest PRECHARGE cycle for both burst lengths;
- the immediate PRECHARGE to another bank;
- PRECHARGE priority over a write when both are requested together.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
   typedef enum logic [1:0] {
      CMD_NOP   = 2'd0,
      CMD_WRITE = 2'd1,
      CMD_PRE   = 2'd2
   } wrb_cmd_e;

   localparam logic [1:0] BL_FIXED8 = 2'b00;
   localparam logic [1:0] BL_OTF    = 2'b01;
   localparam logic [1:0] BL_FIXED4 = 2'b10;
endpackage

// File: rtl/wrb_timer.sv
module wrb_timer #(
   parameter int unsigned WL  = 5,
   parameter int unsigned TWR = 10,
   parameter int unsigned CW  = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          chop,
   output logic          active,
   output logic [CW-1:0] cnt,
   output logic          chop_q,
   output logic          at_last
);
   // last busy cycle index = WL + beats/2 + TWR - 1
   localparam logic [CW-1:0] LAST4 = CW'(WL + 1 + TWR);
   localparam logic [CW-1:0] LAST8 = CW'(WL + 3 + TWR);

   assign at_last = active && (cnt == (chop_q ? LAST4 : LAST8));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         chop_q <= 1'b0;
      end else if (start) begin
         active <= 1'b1;
         cnt    <= '0;
         chop_q <= chop;
      end else if (active) begin
         cnt <= cnt + 1'b1;
         if (at_last) active <= 1'b0;
      end
   end
endmodule

// File: rtl/wrb_strobe.sv
module wrb_strobe #(
   parameter int unsigned WL = 5,
   parameter int unsigned CW = 5
) (
   input  logic          active,
   input  logic [CW-1:0] cnt,
   input  logic          chop_q,
   output logic          dqs_oe,
   output logic          dqs_rise,
   output logic          dqs_fall,
   output logic          dq_oe,
   output logic [1:0]    pair_idx
);
   localparam logic [CW-1:0] WL_C  = CW'(WL);
   localparam logic [CW-1:0] PRE_C = CW'(WL - 1);

   logic [CW-1:0] pairs;
   logic          in_pre, in_data, in_post;

   assign pairs   = chop_q ? CW'(2) : CW'(4);
   assign in_pre  = active && (cnt == PRE_C);
   assign in_data = active && (cnt >= WL_C) && (cnt < WL_C + pairs);
   assign in_post = active && (cnt == WL_C + pairs);

   assign dqs_oe   = in_pre || in_data || in_post;
   assign dqs_rise = in_pre || in_data;
   assign dqs_fall = 1'b0;
   assign dq_oe    = in_data;
   assign pair_idx = 2'(cnt - WL_C);
endmodule

// File: rtl/wrb_beatmux.sv
module wrb_beatmux #(
   parameter int unsigned DW = 8,
   parameter int unsigned MW = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [8*DW-1:0] data_in,
   input  logic [8*MW-1:0] mask_in,
   input  logic            dq_oe,
   input  logic [1:0]      pair_idx,
   output logic [DW-1:0]   dq_rise,
   output logic [DW-1:0]   dq_fall,
   output logic [MW-1:0]   dm_rise,
   output logic [MW-1:0]   dm_fall
);
   logic [8*DW-1:0] data_q;
   logic [8*MW-1:0] mask_q;
   logic [DW-1:0]   beat_d [8];
   logic [MW-1:0]   beat_m [8];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         mask_q <= '0;
      end else if (load) begin
         data_q <= data_in;
         mask_q <= mask_in;
      end
   end

   for (genvar b = 0; b < 8; b++) begin : g_beat
      assign beat_d[b] = data_q[b*DW +: DW];
      assign beat_m[b] = mask_q[b*MW +: MW];
   end

   assign dq_rise = dq_oe ? beat_d[{pair_idx, 1'b0}] : '0;
   assign dq_fall = dq_oe ? beat_d[{pair_idx, 1'b1}] : '0;
   assign dm_rise = dq_oe ? beat_m[{pair_idx, 1'b0}] : '0;
   assign dm_fall = dq_oe ? beat_m[{pair_idx, 1'b1}] : '0;
endmodule

// File: rtl/wrburst_seq.sv
module wrburst_seq
   import wrb_pkg::*;
#(
   parameter int unsigned WL  = 5,
   parameter int unsigned TWR = 10,
   parameter int unsigned DW  = 8,
   parameter int unsigned MW  = DW / 8,
   parameter int unsigned BW  = 3,
   parameter int unsigned CLW = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      mode_bl,
   input  logic            req_valid,
   input  logic [BW-1:0]   req_bank,
   input  logic [CLW-1:0]  req_col,
   input  logic            req_a12,
   input  logic [8*DW-1:0] req_data,
   input  logic [8*MW-1:0] req_mask,
   output logic            req_ready,
   input  logic            pre_req,
   input  logic [BW-1:0]   pre_bank,
   output logic            pre_ack,
   output logic [1:0]      cmd_o,
   output logic [BW-1:0]   cmd_bank,
   output logic [CLW-1:0]  cmd_col,
   output logic            cmd_a12,
   output logic            dqs_oe,
   output logic            dqs_rise,
   output logic            dqs_fall,
   output logic            dq_oe,
   output logic [DW-1:0]   dq_rise,
   output logic [DW-1:0]   dq_fall,
   output logic [MW-1:0]   dm_rise,
   output logic [MW-1:0]   dm_fall
);
   localparam int unsigned CW = $clog2(WL + TWR + 6);

   if (WL < 2) begin : g_bad_wl
      $error("wrburst_seq: WL must be 2 or more");
   end
   if (TWR < 1) begin : g_bad_twr
      $error("wrburst_seq: TWR must be 1 or more");
   end
   if (MW * 8 != DW) begin : g_bad_mw
      $error("wrburst_seq: MW must equal DW/8");
   end

   wrb_cmd_e      cmd_q;
   logic          chop_d, chop_q;
   logic          active, at_last;
   logic [CW-1:0] cnt;
   logic [BW-1:0] wbank_q;
   logic          wr_fire, pre_fire;
   logic [1:0]    pair_idx;

   always_comb begin
      case (mode_bl)
         BL_OTF:    chop_d = !req_a12;
         BL_FIXED4: chop_d = 1'b1;
         default:   chop_d = 1'b0;
      endcase
   end

   assign pre_fire  = pre_req && (!active || (pre_bank != wbank_q) || at_last);
   assign req_ready = !active && !pre_req;
   assign wr_fire   = req_valid && req_ready;
   assign pre_ack   = pre_fire;
   assign cmd_o     = cmd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q    <= CMD_NOP;
         cmd_bank <= '0;
         cmd_col  <= '0;
         cmd_a12  <= 1'b0;
         wbank_q  <= '0;
      end else begin
         cmd_q <= CMD_NOP;
         if (pre_fire) begin
            cmd_q    <= CMD_PRE;
            cmd_bank <= pre_bank;
         end else if (wr_fire) begin
            cmd_q    <= CMD_WRITE;
            cmd_bank <= req_bank;
            cmd_col  <= req_col;
            cmd_a12  <= req_a12;
            wbank_q  <= req_bank;
         end
      end
   end

   wrb_timer #(.WL(WL), .TWR(TWR), .CW(CW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (wr_fire),
      .chop    (chop_d),
      .active  (active),
      .cnt     (cnt),
      .chop_q  (chop_q),
      .at_last (at_last)
   );

   wrb_strobe #(.WL(WL), .CW(CW)) u_strobe (
      .active   (active),
      .cnt      (cnt),
      .chop_q   (chop_q),
      .dqs_oe   (dqs_oe),
      .dqs_rise (dqs_rise),
      .dqs_fall (dqs_fall),
      .dq_oe    (dq_oe),
      .pair_idx (pair_idx)
   );

   wrb_beatmux #(.DW(DW), .MW(MW)) u_beats (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_fire),
      .data_in  (req_data),
      .mask_in  (req_mask),
      .dq_oe    (dq_oe),
      .pair_idx (pair_idx),
      .dq_rise  (dq_rise),
      .dq_fall  (dq_fall),
      .dm_rise  (dm_rise),
      .dm_fall  (dm_fall)
   );
endmodule

// File: rtl/wrb_seq_chk.sv
module wrb_seq_chk #(
   parameter int unsigned WL  = 5,
   parameter int unsigned TWR = 10,
   parameter int unsigned BW  = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    cmd_o,
   input logic [BW-1:0] cmd_bank,
   input logic          req_valid,
   input logic          req_ready,
   input logic          dqs_oe,
   input logic          dqs_rise,
   input logic          dq_oe
);
   logic [15:0]   since_wr;
   logic [15:0]   pairs_seen;
   logic [BW-1:0] wr_bank;
   logic          seen_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_wr   <= '0;
         pairs_seen <= '0;
         wr_bank    <= '0;
         seen_wr    <= 1'b0;
      end else begin
         if (cmd_o == 2'd1) begin
            since_wr   <= 16'd1;
            pairs_seen <= '0;
            wr_bank    <= cmd_bank;
            seen_wr    <= 1'b1;
         end else begin
            if (since_wr != 16'hFFFF) since_wr <= since_wr + 16'd1;
            if (dq_oe) pairs_seen <= pairs_seen + 16'd1;
         end
      end
   end

   // R2
   write_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 2'd1) |-> $past(req_valid && req_ready));

   // R2
   busy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 2'd1) |-> !req_ready);

   // R4
   dq_inside_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> dqs_oe);

   // R5
   preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe) |-> $past(dqs_oe && dqs_rise && !dq_oe));

   // R6
   postamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dq_oe) |-> (dqs_oe && !dqs_rise));

   // R8
   recovery_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 2'd2 && seen_wr && cmd_bank == wr_bank)
         |-> (since_wr >= 16'(WL + TWR) + pairs_seen));
endmodule

bind wrburst_seq wrb_seq_chk #(.WL(WL), .TWR(TWR), .BW(BW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_o     (cmd_o),
   .cmd_bank  (cmd_bank),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .dqs_oe    (dqs_oe),
   .dqs_rise  (dqs_rise),
   .dq_oe     (dq_oe)
);

// File: tb/wrburst_seq_tb.sv
`timescale 1ns/1ps
module wrburst_seq_tb;
   localparam int WL  = 5;
   localparam int TWR = 10;
   localparam int DW  = 8;
   localparam int MW  = 1;
   localparam int BW  = 3;
   localparam int CLW = 10;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [1:0]      mode_bl;
   logic            req_valid;
   logic [BW-1:0]   req_bank;
   logic [CLW-1:0]  req_col;
   logic            req_a12;
   logic [8*DW-1:0] req_data;
   logic [8*MW-1:0] req_mask;
   logic            req_ready;
   logic            pre_req;
   logic [BW-1:0]   pre_bank;
   logic            pre_ack;
   logic [1:0]      cmd_o;
   logic [BW-1:0]   cmd_bank;
   logic [CLW-1:0]  cmd_col;
   logic            cmd_a12;
   logic            dqs_oe, dqs_rise, dqs_fall, dq_oe;
   logic [DW-1:0]   dq_rise, dq_fall;
   logic [MW-1:0]   dm_rise, dm_fall;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   wrburst_seq #(.WL(WL), .TWR(TWR), .DW(DW), .MW(MW), .BW(BW), .CLW(CLW)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_bl(mode_bl), .req_valid(req_valid),
      .req_bank(req_bank), .req_col(req_col), .req_a12(req_a12),
      .req_data(req_data), .req_mask(req_mask), .req_ready(req_ready),
      .pre_req(pre_req), .pre_bank(pre_bank), .pre_ack(pre_ack),
      .cmd_o(cmd_o), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_a12(cmd_a12),
      .dqs_oe(dqs_oe), .dqs_rise(dqs_rise), .dqs_fall(dqs_fall), .dq_oe(dq_oe),
      .dq_rise(dq_rise), .dq_fall(dq_fall), .dm_rise(dm_rise), .dm_fall(dm_fall)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // R3: pairs of beats per burst
   function automatic int exp_pairs(input logic [1:0] mode, input logic a12);
      if (mode == 2'b01) return a12 ? 4 : 2;
      if (mode == 2'b10) return 2;
      return 4;
   endfunction

   // psel: 0 none, 1 same-bank precharge, 2 other-bank precharge
   task automatic run_burst(input logic [1:0] mode, input logic a12, input logic [BW-1:0] bank,
                            input logic [CLW-1:0] col, input logic [63:0] data,
                            input logic [7:0] mask, input int psel);
      int h, last;
      logic [BW-1:0] pb;
      logic [1:0] ecmd;
      h    = exp_pairs(mode, a12);
      last = WL + h + TWR - 1;
      pb   = (psel == 2) ? (bank ^ 3'd1) : bank;
      @(negedge clk);
      mode_bl = mode; req_a12 = a12; req_bank = bank; req_col = col;
      req_data = data; req_mask = mask; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k <= last + 2; k++) begin
         if (k > 0) @(negedge clk);
         ecmd = 2'd0;
         if (k == 0) ecmd = 2'd1;
         if (psel == 1 && k == last + 1) ecmd = 2'd2;
         if (psel == 2 && k == 1) ecmd = 2'd2;
         check($sformatf("R11 R8 R9 cmd k=%0d", k), 64'(cmd_o), 64'(ecmd));
         if (k == 0) begin
            check("R2 cmd_bank", 64'(cmd_bank), 64'(bank));
            check("R2 cmd_col", 64'(cmd_col), 64'(col));
            check("R2 cmd_a12", 64'(cmd_a12), 64'(a12));
         end
         if (ecmd == 2'd2) check("R9 pre bank", 64'(cmd_bank), 64'(pb));
         check($sformatf("R5 R6 dqs_oe k=%0d", k), 64'(dqs_oe),
               64'(k >= WL - 1 && k <= WL + h));
         check($sformatf("R5 R6 dqs_rise k=%0d", k), 64'(dqs_rise),
               64'(k >= WL - 1 && k < WL + h));
         check("R5 dqs_fall", 64'(dqs_fall), 64'd0);
         check($sformatf("R3 R4 dq_oe k=%0d", k), 64'(dq_oe), 64'(k >= WL && k < WL + h));
         if (k >= WL && k < WL + h) begin
            check($sformatf("R4 dq_rise k=%0d", k), 64'(dq_rise), 64'(data[(2*(k-WL))*DW +: DW]));
            check($sformatf("R4 dq_fall k=%0d", k), 64'(dq_fall), 64'(data[(2*(k-WL)+1)*DW +: DW]));
            check($sformatf("R7 dm_rise k=%0d", k), 64'(dm_rise), 64'(mask[(2*(k-WL))*MW +: MW]));
            check($sformatf("R7 dm_fall k=%0d", k), 64'(dm_fall), 64'(mask[(2*(k-WL)+1)*MW +: MW]));
         end else begin
            check("R4 dq idle", 64'({dq_rise, dq_fall}), 64'd0);
         end
         if (k <= last) check($sformatf("R2 busy k=%0d", k), 64'(req_ready), 64'd0);
         if (k == last + 2) check("R2 ready again", 64'(req_ready), 64'd1);
         if (psel != 0 && k == 0) begin
            pre_req = 1'b1;
            pre_bank = pb;
         end
         if (psel == 2 && k == 1) pre_req = 1'b0;
         if (psel == 1 && k == last + 1) pre_req = 1'b0;
      end
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; mode_bl = 2'b01; req_valid = 1'b0; req_bank = '0; req_col = '0;
      req_a12 = 1'b0; req_data = '0; req_mask = '0; pre_req = 1'b0; pre_bank = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 cmd", 64'(cmd_o), 64'd0);
      check("R1 dqs_oe", 64'(dqs_oe), 64'd0);
      check("R1 dq_oe", 64'(dq_oe), 64'd0);
      check("R1 ready", 64'(req_ready), 64'd1);
      check("R1 pre_ack", 64'(pre_ack), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset cmd", 64'(cmd_o), 64'd0);

      // directed: R3 on-the-fly chop and full, fixed modes ignoring a12
      run_burst(2'b01, 1'b0, 3'd2, 10'h040, 64'h8877665544332211, 8'hA5, 1);
      run_burst(2'b01, 1'b1, 3'd5, 10'h108, 64'h0F1E2D3C4B5A6978, 8'h3C, 1);
      run_burst(2'b00, 1'b0, 3'd1, 10'h3F8, 64'hDEADBEEFCAFEF00D, 8'h81, 0);
      run_burst(2'b10, 1'b1, 3'd6, 10'h010, 64'h0123456789ABCDEF, 8'h5A, 2);
      run_burst(2'b11, 1'b0, 3'd0, 10'h200, 64'hFEDCBA9876543210, 8'hF0, 1);

      // R10: precharge and write requested together while idle
      @(negedge clk);
      pre_req = 1'b1; pre_bank = 3'd3; req_valid = 1'b1; req_bank = 3'd4;
      #1;
      check("R10 ready low", 64'(req_ready), 64'd0);
      check("R10 pre_ack", 64'(pre_ack), 64'd1);
      @(negedge clk);
      check("R10 cmd pre", 64'(cmd_o), 64'd2);
      check("R10 pre bank", 64'(cmd_bank), 64'd3);
      pre_req = 1'b0; req_valid = 1'b0;
      @(negedge clk);
      check("R11 nop after pre", 64'(cmd_o), 64'd0);
      check("R10 ready back", 64'(req_ready), 64'd1);

      // constrained random bursts
      for (int n = 0; n < 24; n++) begin
         run_burst(2'($urandom_range(3)), 1'($urandom_range(1)), 3'($urandom_range(7)),
                   10'($urandom), {$urandom, $urandom}, 8'($urandom), int'($urandom_range(2)));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule